// File: doc/BRIEF.md
# Prioritised 64-source interrupt controller

This block gathers 64 level-sensitive interrupt lines into two processor-facing request outputs: a normal request and a fast request. Every source carries four pieces of state: a pending bit, an enable bit, a routing bit that selects the fast path, and a 4-bit priority. Software reaches all of it through a 32-bit register bus with word addresses.

The fast request rises whenever some pending, enabled source is routed to the fast path. The normal request is gated by a 5-bit threshold. When the threshold holds its all-ones value, no gating applies. Otherwise, only a source whose priority is strictly above the threshold can raise the request.

Software can enable or disable one source by writing its number. It can also load the enable set and the routing set one 32-bit half at a time. It can overwrite the pending set for one cycle, and it can read the raw pending set as well as the filtered sets for each output. Per-source vector registers and vector arbitration are not part of this block; writes to the vector area are discarded.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, the pending, enable, routing and priority state and the control register read zero, the threshold reads 0x1F, and both request outputs are low.
- R2: Each clock the pending set samples `src_i`, so a pending bit equals its input level one cycle earlier. Word 18 reads pending[63:32] and word 19 reads pending[31:0].
- R3: A write to word 20 or word 21 replaces pending[63:32] or pending[31:0] with the write data for that cycle, and it wins over input sampling. Both words read zero.
- R4: A write to word 2 sets enable bit wdata[5:0], and a write to word 3 clears that bit. Both words read zero.
- R5: Words 4 and 5 read and write enable[63:32] and enable[31:0]. Words 6 and 7 read and write the routing bits [63:32] and [31:0]; a routing bit of 1 means fast.
- R6: Source i has its priority in bits [4*(i%8)+3 : 4*(i%8)] of priority word i/8. Priority word k sits at bus word 15-k, so word 15 holds sources 0-7 and word 8 holds sources 56-63.
- R7: The fast output is high two clocks after some source is pending, enabled and routed fast, and it is low otherwise.
- R8: With the threshold at 0x1F, the normal output is high if any source is pending, enabled and not routed fast. With any other threshold, such a source must also have a priority strictly above the threshold. The output follows this condition with the same two-clock delay as the fast output.
- R9: Word 1 holds the threshold. Only wdata[4:0] is kept, and the upper read bits are zero.
- R10: Word 0 is the control register. Only bits 24 and 22..18 are stored, and bit 25 is a write-one-to-clear flag that no event sets, so it reads zero.
- R11: Words 22/23 read pending AND enable AND NOT routing, and words 24/25 read pending AND enable AND routing, each split into upper and lower halves. Writes to words 16-19 and 22-25 change nothing.
- R12: Reads of unmapped words, including the vector area at words 64-191, return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W (10) | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_norm_o | output | 1 | Normal interrupt request, level |
| irq_fast_o | output | 1 | Fast interrupt request, level |

## Verification
The hardest condition to reach from the ports is a forced pending value. Input sampling overwrites it one clock later, so it only shows in the single cycle after the force write. The stimulus therefore issues the read strobe in the very next cycle, holds an input level that disagrees with the forced data, and checks that the forced value wins. The priority threshold boundary is the other delicate point, since priority and threshold are equal there. It is tested for sources 0 and 63, which sit in the first and last priority words, so that the reversed word order is covered.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
    localparam int NSRC          = 64;
    localparam int HALF          = NSRC / 2;
    localparam int SRC_IDX_W     = $clog2(NSRC);
    localparam int PRIO_W        = 4;
    localparam int PRIO_PER_WORD = 32 / PRIO_W;
    localparam int PRIO_WORDS    = NSRC / PRIO_PER_WORD;
    localparam int PWORD_IDX_W   = $clog2(PRIO_WORDS);
    localparam int MASK_W        = 5;
    localparam logic [MASK_W-1:0] THR_OPEN = '1;

    // word offsets
    localparam int W_CTRL     = 0;
    localparam int W_THR      = 1;
    localparam int W_EN_NUM   = 2;
    localparam int W_DIS_NUM  = 3;
    localparam int W_EN_HI    = 4;
    localparam int W_EN_LO    = 5;
    localparam int W_TY_HI    = 6;
    localparam int W_TY_LO    = 7;
    localparam int W_PRIO_LO  = 8;
    localparam int W_PRIO_HI  = 15;
    localparam int W_SRC_HI   = 18;
    localparam int W_SRC_LO   = 19;
    localparam int W_FRC_HI   = 20;
    localparam int W_FRC_LO   = 21;
    localparam int W_NP_HI    = 22;
    localparam int W_NP_LO    = 23;
    localparam int W_FP_HI    = 24;
    localparam int W_FP_LO    = 25;

    localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
    localparam int CTRL_FLAG    = 25;
    localparam int CTRL_FLAG_EN = 24;

    typedef logic [NSRC-1:0] srcvec_t;
    typedef logic [PRIO_WORDS-1:0][31:0] prio_arr_t;

    typedef struct packed {
        srcvec_t          pend;
        srcvec_t          en;
        srcvec_t          typ;
        prio_arr_t        prio;
        logic [31:0]      ctrl;
        logic [MASK_W-1:0] thr;
        logic [31:0]      rdata;
    } regs_t;

    typedef struct packed {
        logic norm;
        logic fast;
    } outs_t;
endpackage

// File: rtl/irqh_eval.sv
module irqh_eval
    import irqh_pkg::*;
(
    input  srcvec_t           pend_i,
    input  srcvec_t           en_i,
    input  srcvec_t           typ_i,
    input  prio_arr_t         prio_i,
    input  logic [MASK_W-1:0] thr_i,
    output logic              norm_req_o,
    output logic              fast_req_o
);
    srcvec_t live_norm;
    srcvec_t above_thr;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int WI = g / PRIO_PER_WORD;
        localparam int LSB = PRIO_W * (g % PRIO_PER_WORD);
        assign live_norm[g] = pend_i[g] & en_i[g] & ~typ_i[g];
        assign above_thr[g] = live_norm[g] &&
            ({{(MASK_W-PRIO_W){1'b0}}, prio_i[WI][LSB +: PRIO_W]} > thr_i);
    end

    always_comb begin
        fast_req_o = |(pend_i & en_i & typ_i);
        if (thr_i == THR_OPEN) norm_req_o = |live_norm;
        else                   norm_req_o = |above_thr;
    end
endmodule

// File: rtl/irqh_regfile.sv
module irqh_regfile
    import irqh_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  srcvec_t           src_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output srcvec_t           pend_o,
    output srcvec_t           en_o,
    output srcvec_t           typ_o,
    output prio_arr_t         prio_o,
    output logic [MASK_W-1:0] thr_o
);
    localparam regs_t REGS_RST = '{pend: '0, en: '0, typ: '0, prio: '0,
                                   ctrl: '0, thr: THR_OPEN, rdata: '0};

    regs_t s_d, s_q;
    int    a;
    logic  [PWORD_IDX_W-1:0] widx;
    logic  [31:0] rd_val;
    srcvec_t np_set, fp_set;

    always_comb begin
        a      = int'(addr_i);
        widx   = PWORD_IDX_W'(W_PRIO_HI - a);
        np_set = s_q.pend & s_q.en & ~s_q.typ;
        fp_set = s_q.pend & s_q.en & s_q.typ;

        rd_val = '0;
        case (a)
            W_CTRL:   rd_val = s_q.ctrl;
            W_THR:    rd_val = {{(32-MASK_W){1'b0}}, s_q.thr};
            W_EN_HI:  rd_val = s_q.en[NSRC-1:HALF];
            W_EN_LO:  rd_val = s_q.en[HALF-1:0];
            W_TY_HI:  rd_val = s_q.typ[NSRC-1:HALF];
            W_TY_LO:  rd_val = s_q.typ[HALF-1:0];
            W_SRC_HI: rd_val = s_q.pend[NSRC-1:HALF];
            W_SRC_LO: rd_val = s_q.pend[HALF-1:0];
            W_NP_HI:  rd_val = np_set[NSRC-1:HALF];
            W_NP_LO:  rd_val = np_set[HALF-1:0];
            W_FP_HI:  rd_val = fp_set[NSRC-1:HALF];
            W_FP_LO:  rd_val = fp_set[HALF-1:0];
            default: begin
                if (a >= W_PRIO_LO && a <= W_PRIO_HI) rd_val = s_q.prio[widx];
            end
        endcase

        s_d      = s_q;
        s_d.pend = src_i;
        if (rd_i) s_d.rdata = rd_val;
        if (wr_i) begin
            case (a)
                W_CTRL: begin
                    s_d.ctrl = wdata_i & CTRL_KEEP;
                    if (s_d.ctrl[CTRL_FLAG_EN])
                        s_d.ctrl[CTRL_FLAG] = s_d.ctrl[CTRL_FLAG] & ~wdata_i[CTRL_FLAG];
                end
                W_THR:     s_d.thr = wdata_i[MASK_W-1:0];
                W_EN_NUM:  s_d.en[wdata_i[SRC_IDX_W-1:0]] = 1'b1;
                W_DIS_NUM: s_d.en[wdata_i[SRC_IDX_W-1:0]] = 1'b0;
                W_EN_HI:   s_d.en[NSRC-1:HALF] = wdata_i;
                W_EN_LO:   s_d.en[HALF-1:0] = wdata_i;
                W_TY_HI:   s_d.typ[NSRC-1:HALF] = wdata_i;
                W_TY_LO:   s_d.typ[HALF-1:0] = wdata_i;
                W_FRC_HI:  s_d.pend[NSRC-1:HALF] = wdata_i;
                W_FRC_LO:  s_d.pend[HALF-1:0] = wdata_i;
                default: begin
                    if (a >= W_PRIO_LO && a <= W_PRIO_HI) s_d.prio[widx] = wdata_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= REGS_RST;
        else         s_q <= s_d;
    end

    assign rdata_o = s_q.rdata;
    assign pend_o  = s_q.pend;
    assign en_o    = s_q.en;
    assign typ_o   = s_q.typ;
    assign prio_o  = s_q.prio;
    assign thr_o   = s_q.thr;

    // R2: without a force write, pending mirrors last cycle's inputs
    p_pend_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && (int'(addr_i) == W_FRC_HI || int'(addr_i) == W_FRC_LO))
        |=> pend_o == $past(src_i));

    // R3: a force write to the low half lands on pending[31:0]
    p_force_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && int'(addr_i) == W_FRC_LO) |=> pend_o[HALF-1:0] == $past(wdata_i));

    // R4: number and force words read as zero
    p_zero_words_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && (int'(addr_i) == W_EN_NUM || int'(addr_i) == W_DIS_NUM ||
                  int'(addr_i) == W_FRC_HI || int'(addr_i) == W_FRC_LO))
        |=> rdata_o == 32'h0);

    // R10: control read never shows a bit outside the stored set
    p_ctrl_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && int'(addr_i) == W_CTRL) |=> (rdata_o & ~CTRL_KEEP) == 32'h0);
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
    import irqh_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [63:0]       src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_norm_o,
    output logic              irq_fast_o
);
    srcvec_t           pend, en, typ;
    prio_arr_t         prio;
    logic [MASK_W-1:0] thr;
    logic              norm_req, fast_req;
    outs_t             o_d, o_q;

    irqh_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .pend_o  (pend),
        .en_o    (en),
        .typ_o   (typ),
        .prio_o  (prio),
        .thr_o   (thr)
    );

    irqh_eval u_eval (
        .pend_i     (pend),
        .en_i       (en),
        .typ_i      (typ),
        .prio_i     (prio),
        .thr_i      (thr),
        .norm_req_o (norm_req),
        .fast_req_o (fast_req)
    );

    always_comb begin
        o_d.norm = norm_req;
        o_d.fast = fast_req;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign irq_norm_o = o_q.norm;
    assign irq_fast_o = o_q.fast;

    // R7: fast output follows the fast-routed live set one cycle later
    p_fast_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_fast_o == $past(|(pend & en & typ)));

    // R8: open threshold passes any live normal source
    p_open_thr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thr == THR_OPEN && |(pend & en & ~typ)) |=> irq_norm_o);

    // R8: a threshold of 15..30 can never be exceeded by a 4-bit priority
    p_strict_thr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thr != THR_OPEN && thr >= MASK_W'(15)) |=> !irq_norm_o);

    // R8: nothing live on the normal path keeps the output low
    p_norm_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(pend & en & ~typ)) |=> !irq_norm_o);
endmodule

// File: tb/prio_irq_hub_bench.sv
`timescale 1ns/1ps
module prio_irq_hub_bench;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   src = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_n, irq_f;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_hub #(.ADDR_W(AW)) u_prio_irq_hub (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_wr_i(wr_en), .bus_rd_i(rd_en), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_norm_o(irq_n), .irq_fast_o(irq_f)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = AW'(a);
        @(posedge clk); #1; v = rdata; rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic clean();
        src = '0;
        wr(5, 0); wr(4, 0); wr(7, 0); wr(6, 0); wr(1, 32'h1F);
        for (int k = 8; k <= 15; k++) wr(k, 0);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 thr", v, 32'h1F);
        rd(5, v); check("R1 en_lo", v, 0);
        rd(6, v); check("R1 typ_hi", v, 0);
        rd(12, v); check("R1 prio", v, 0);
        rd(19, v); check("R1 pend_lo", v, 0);
        check("R1 outs", {30'b0, irq_n, irq_f}, 0);
    endtask

    task automatic t_number();
        logic [31:0] v;
        clean();
        wr(2, 32'h45); rd(5, v); check("R4 enable by number low", v, 32'h20);
        wr(2, 32'h3F); rd(4, v); check("R4 enable by number 63", v, 32'h8000_0000);
        rd(2, v); check("R4 en num reads zero", v, 0);
        rd(3, v); check("R4 dis num reads zero", v, 0);
        wr(3, 32'h05); rd(5, v); check("R4 disable by number", v, 0);
        rd(4, v); check("R4 other bit kept", v, 32'h8000_0000);
    endtask

    task automatic t_halves();
        logic [31:0] v;
        clean();
        wr(5, 32'hA5A5_5A5A); rd(5, v); check("R5 en_lo", v, 32'hA5A5_5A5A);
        rd(4, v); check("R5 en_hi untouched", v, 0);
        wr(6, 32'h1234_5678); rd(6, v); check("R5 typ_hi", v, 32'h1234_5678);
        rd(7, v); check("R5 typ_lo untouched", v, 0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        clean();
        wr(15, 32'h0000_00F3); rd(15, v); check("R6 word0 at 15", v, 32'hF3);
        rd(8, v); check("R6 word7 at 8 separate", v, 0);
        wr(2, 0); src = 64'h1; wr(1, 2); settle();
        check("R8 prio3 above thr2", {31'b0, irq_n}, 1);
        wr(1, 3); settle();
        check("R8 prio3 equal thr3 blocked", {31'b0, irq_n}, 0);
        wr(3, 0); wr(8, 32'h9000_0000); wr(2, 63);
        src = 64'h8000_0000_0000_0000; wr(1, 8); settle();
        check("R6 src63 prio9 above thr8", {31'b0, irq_n}, 1);
        wr(1, 9); settle();
        check("R6 src63 prio9 equal thr9", {31'b0, irq_n}, 0);
    endtask

    task automatic t_thr();
        logic [31:0] v;
        clean();
        wr(2, 0); src = 64'h1; wr(1, 32'h1F); settle();
        check("R8 open thr prio0", {31'b0, irq_n}, 1);
        wr(1, 0); settle();
        check("R8 prio0 thr0 blocked", {31'b0, irq_n}, 0);
        wr(15, 32'hF); wr(1, 32'h1E); settle();
        check("R8 thr30 blocks prio15", {31'b0, irq_n}, 0);
        wr(1, 32'hFFFF_FFE7); rd(1, v); check("R9 thr keeps 5 bits", v, 32'h07);
        settle(); check("R8 prio15 above thr7", {31'b0, irq_n}, 1);
    endtask

    task automatic t_fast();
        clean();
        wr(7, 1); wr(2, 0); src = 64'h1; settle();
        check("R7 fast high", {31'b0, irq_f}, 1);
        check("R8 normal low for fast source", {31'b0, irq_n}, 0);
        wr(3, 0); settle();
        check("R7 fast low when disabled", {31'b0, irq_f}, 0);
    endtask

    task automatic t_pend();
        logic [31:0] v;
        clean();
        src = 64'h0000_0100_0000_0000; settle();
        rd(18, v); check("R2 src_hi follows input", v, 32'h100);
        src = '0; settle();
        rd(18, v); check("R2 src_hi clears", v, 0);
        src = 64'h2;
        wr(21, 32'h11); rd(19, v); check("R3 force wins over input", v, 32'h11);
        rd(19, v); check("R2 pending back to input", v, 32'h2);
        rd(21, v); check("R3 force reads zero", v, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF); rd(0, v); check("R10 ctrl kept bits", v, 32'h017C_0000);
        wr(0, 32'h0000_0000); rd(0, v); check("R10 ctrl clear", v, 0);
    endtask

    task automatic t_filtered();
        logic [31:0] v;
        clean();
        src = 64'h3; wr(5, 3); wr(7, 2); settle();
        rd(23, v); check("R11 normal filtered", v, 32'h1);
        rd(25, v); check("R11 fast filtered", v, 32'h2);
        rd(19, v); check("R11 raw set", v, 32'h3);
        wr(23, 32'hFFFF_FFFF); wr(19, 0); wr(17, 32'hFFFF); rd(5, v);
        check("R11 writes to read-only ignored", v, 32'h3);
        rd(23, v); check("R11 filtered unchanged", v, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        clean();
        wr(5, 32'h0F); wr(100, 32'hFFFF_FFFF); wr(30, 32'hFFFF_FFFF);
        rd(5, v); check("R12 vector write ignored", v, 32'h0F);
        rd(15, v); check("R12 prio unchanged", v, 0);
        rd(30, v); check("R12 unmapped reads zero", v, 0);
        rd(100, v); check("R12 vector area reads zero", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        check("R1 outs in reset", {30'b0, irq_n, irq_f}, 0);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_number();
        t_halves();
        t_prio();
        t_thr();
        t_fast();
        t_pend();
        t_ctrl();
        t_filtered();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule